// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a linear address into a physical address by walking a two-level translation structure held in memory. A translation request carries a linear address. When the paging enable input is low at the moment the request is accepted, the block returns that address unchanged. When it is high, the block reads a directory entry and then a page-table entry through a single memory read port. It then joins the frame number from the second entry with the byte offset of the linear address.

Every entry carries a present flag in bit 0. If either entry is marked absent, the walk stops and the response reports a page fault together with the faulting linear address. Only one translation is in flight at a time.

All three streams use valid/ready. A transfer happens on a rising edge where both valid and ready are high. A source that raises valid keeps valid and its payload steady until that edge, and the walker never waits on its own valid to raise ready. The memory response has no ready: the walker only has one read outstanding and takes the data in any cycle it is offered.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req_valid are 0.
- R2: A request accepted while paging_en is 0 responds with rsp_paddr equal to the request address and rsp_fault 0, and issues no memory read. paging_en is sampled only at acceptance.
- R3: The first read of a walk uses the address {dir_base[31:12], laddr[31:22], 2'b00}. Bits 11:0 of dir_base have no effect.
- R4: The second read uses the address {D[31:12], laddr[21:12], 2'b00}, where D is the directory entry. Bits 11:1 of that entry have no effect.
- R5: When both entries have bit 0 set, the response is rsp_fault 0 and rsp_paddr = {T[31:12], laddr[11:0]}, where T is the page-table entry.
- R6: A directory entry with bit 0 clear ends the walk after one read, with rsp_fault 1 and rsp_paddr equal to the linear address.
- R7: A page-table entry with bit 0 clear ends the walk after two reads, with rsp_fault 1 and rsp_paddr equal to the linear address.
- R8: From an accepted request until its response is taken, req_ready stays 0. The request inputs are ignored in that span.
- R9: While rsp_valid is 1 and rsp_ready is 0, the response stays valid and unchanged.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, the read request stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| paging_en | input | 1 | Translation enable, sampled when a request is accepted |
| dir_base | input | 32 | Directory base; bits 31:12 are used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, or the faulting linear address |
| rsp_fault | output | 1 | Page fault flag |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 12-bit offset and 10-bit indices. Its memory model computes each entry arithmetically from the address it is asked for. A sweep over all 1024 directory indices therefore reaches every directory slot. The rules for the present flag make both fault kinds and clean walks occur many times across that sweep. Junk in the ignored low bits of the entries and of the base confirms those bits are masked. Varied memory latencies and response stalls exercise the hold rules on both handshakes. A bypass series, including the all-zero and all-one addresses, covers the disabled path.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    W_IDLE  = 3'd0,
    W_DREQ  = 3'd1,
    W_DWAIT = 3'd2,
    W_TREQ  = 3'd3,
    W_TWAIT = 3'd4,
    W_RESP  = 3'd5
  } walk_state_t;

  localparam int PRESENT_BIT = 0;
  localparam int ENTRY_SHIFT = 2;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 12,
  parameter int IDX_W    = 10
) (
  input  logic [ADDR_W-OFF_BITS-1:0] frame,
  input  logic [IDX_W-1:0]           idx,
  output logic [ADDR_W-1:0]          addr
);
  localparam int SLOT_W = OFF_BITS - pw_pkg::ENTRY_SHIFT;
  logic [SLOT_W-1:0] slot;
  assign slot = SLOT_W'(idx);
  assign addr = {frame, slot, {pw_pkg::ENTRY_SHIFT{1'b0}}};
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       paging_en,
  input  logic [ADDR_W-OFF_BITS-1:0] base_frame,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_laddr,
  output logic                       rsp_valid,
  output logic [ADDR_W-1:0]          rsp_paddr,
  output logic                       rsp_fault,
  input  logic                       rsp_ready,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  input  logic                       mem_rsp_valid,
  input  logic [ADDR_W-1:0]          mem_rsp_data,
  output logic                       tbl_stage,
  output logic [ADDR_W-1:0]          lad_q,
  output logic [ADDR_W-OFF_BITS-1:0] base_q,
  output logic [ADDR_W-OFF_BITS-1:0] dent_q
);
  localparam int FRAME_W = ADDR_W - OFF_BITS;

  walk_state_t st;
  logic [ADDR_W-1:0] paddr_q;
  logic fault_q;
  logic present;
  logic [FRAME_W-1:0] rd_frame;
  logic unused_entry_bits;

  assign present  = mem_rsp_data[PRESENT_BIT];
  assign rd_frame = mem_rsp_data[ADDR_W-1:OFF_BITS];
  assign unused_entry_bits = ^mem_rsp_data[OFF_BITS-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      lad_q   <= '0;
      base_q  <= '0;
      dent_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (req_valid) begin
          lad_q  <= req_laddr;
          base_q <= base_frame;
          if (paging_en) st <= W_DREQ;
          else begin
            paddr_q <= req_laddr;
            fault_q <= 1'b0;
            st      <= W_RESP;
          end
        end
        W_DREQ: if (mem_req_ready) st <= W_DWAIT;
        W_DWAIT: if (mem_rsp_valid) begin
          if (!present) begin
            paddr_q <= lad_q;
            fault_q <= 1'b1;
            st      <= W_RESP;
          end else begin
            dent_q <= rd_frame;
            st     <= W_TREQ;
          end
        end
        W_TREQ: if (mem_req_ready) st <= W_TWAIT;
        W_TWAIT: if (mem_rsp_valid) begin
          if (!present) begin
            paddr_q <= lad_q;
            fault_q <= 1'b1;
          end else begin
            paddr_q <= {rd_frame, lad_q[OFF_BITS-1:0]};
            fault_q <= 1'b0;
          end
          st <= W_RESP;
        end
        W_RESP: if (rsp_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == W_IDLE);
  assign rsp_valid     = (st == W_RESP);
  assign mem_req_valid = (st == W_DREQ) || (st == W_TREQ);
  assign tbl_stage     = (st == W_TREQ);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paging_en,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int FRAME_W  = ADDR_W - OFF_BITS;
  localparam int TBL_BITS = OFF_BITS - pw_pkg::ENTRY_SHIFT;
  localparam int DIR_BITS = ADDR_W - OFF_BITS - TBL_BITS;

  logic                tbl_stage;
  logic [ADDR_W-1:0]   lad_q;
  logic [FRAME_W-1:0]  base_q;
  logic [FRAME_W-1:0]  dent_q;
  logic [ADDR_W-1:0]   dir_addr;
  logic [ADDR_W-1:0]   tbl_addr;
  logic                unused_base_bits;

  assign unused_base_bits = ^dir_base[OFF_BITS-1:0];

  pw_ctrl #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en),
    .base_frame(dir_base[ADDR_W-1:OFF_BITS]),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_ready(rsp_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tbl_stage(tbl_stage), .lad_q(lad_q), .base_q(base_q), .dent_q(dent_q)
  );

  pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_W(DIR_BITS)) u_dir_addr (
    .frame(base_q), .idx(lad_q[ADDR_W-1 -: DIR_BITS]), .addr(dir_addr)
  );

  pw_entry_addr #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .IDX_W(TBL_BITS)) u_tbl_addr (
    .frame(dent_q), .idx(lad_q[OFF_BITS +: TBL_BITS]), .addr(tbl_addr)
  );

  assign mem_req_addr = tbl_stage ? tbl_addr : dir_addr;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              paging_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_laddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !mem_req_valid));

  // R2
  bypass_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !paging_en) |=>
      (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr) && !mem_req_valid));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_pt_walker_chk (
  .clk(clk), .rst_n(rst_n), .paging_en(paging_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_en = 1'b0;
  logic [31:0] dir_base = 32'h0040_0ABC;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int checks = 0;
  int failures = 0;
  int n_reads = 0;
  int mlat = 0;
  logic [31:0] exp_a0, exp_a1;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a);
    int d, t;
    if (a[31:12] == 20'h00400) begin
      d = int'(a[11:2]);
      return {20'h10000 + 20'(d), 11'h5A5, (d % 7) != 3};
    end
    d = int'(a[31:12]) - 32'h10000;
    t = int'(a[11:2]);
    return {(20'(d) << 10 | 20'(t)) ^ 20'hABCDE, 11'h3C3, ((d + t) % 5) != 2};
  endfunction

  // memory model: variable accept and data latency
  initial begin
    logic [31:0] a;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (mlat % 2) @(negedge clk);
        a = mem_req_addr;
        if (n_reads == 0) chk(a == exp_a0, "R3 directory entry address", a, exp_a0);
        else chk(a == exp_a1, "R4 table entry address", a, exp_a1);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (mlat % 3) @(negedge clk);
        mem_rsp_data  = model(a);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
        mlat++;
        n_reads++;
      end
    end
  end

  task automatic xlate(input logic [31:0] la, input bit en, input int stall, input string tag);
    int d, t, exp_n;
    logic [31:0] exp_pa, hold_pa;
    logic exp_f, hold_f;
    d = int'(la[31:22]);
    t = int'(la[21:12]);
    exp_a0 = {20'h00400, la[31:22], 2'b00};
    exp_a1 = {20'h10000 + 20'(d), la[21:12], 2'b00};
    if (!en) begin exp_pa = la; exp_f = 1'b0; exp_n = 0; end
    else if ((d % 7) == 3) begin exp_pa = la; exp_f = 1'b1; exp_n = 1; end
    else if (((d + t) % 5) == 2) begin exp_pa = la; exp_f = 1'b1; exp_n = 2; end
    else begin
      exp_pa = {(20'(d) << 10 | 20'(t)) ^ 20'hABCDE, la[11:0]};
      exp_f = 1'b0; exp_n = 2;
    end
    n_reads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la; paging_en = en;
    @(negedge clk);
    req_valid = 1'b1; req_laddr = ~la; paging_en = !en;  // R8: ignored while busy
    chk(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    hold_pa = rsp_paddr; hold_f = rsp_fault;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == hold_pa && rsp_fault == hold_f, "R9 response held",
          rsp_paddr, hold_pa);
      chk(req_ready == 1'b0, "R8 no accept while holding", 32'(req_ready), 32'd0);
    end
    chk(rsp_paddr == exp_pa, tag, rsp_paddr, exp_pa);
    chk(rsp_fault == exp_f, tag, 32'(rsp_fault), 32'(exp_f));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8 ready after response", 32'(req_ready), 32'd1);
    chk(n_reads == exp_n, "R2/R6/R7 memory read count", 32'(n_reads), 32'(exp_n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 reset valids",
        32'({rsp_valid, mem_req_valid}), 32'd0);
    rst_n = 1'b1;
    // R2 bypass series, including extremes
    xlate(32'h0000_0000, 1'b0, 0, "R2 bypass zero");
    xlate(32'hFFFF_FFFF, 1'b0, 2, "R2 bypass ones");
    for (int k = 0; k < 64; k++)
      xlate(32'h9E37_79B9 * 32'(k + 1), 1'b0, k % 3, "R2 bypass sweep");
    // R3 R4 R5 R6 R7: sweep every directory index
    for (int d = 0; d < 1024; d++) begin
      logic [31:0] la;
      la = {10'(d), 10'((d * 37 + 5) & 1023), 12'((d * 13) & 4095)};
      xlate(la, 1'b1, d % 3, "R5/R6/R7 walk result");
    end
    xlate(32'hFFFF_FFFF, 1'b1, 1, "R5 walk ones");
    xlate(32'h0000_0000, 1'b1, 0, "R5 walk zero");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule